// File: doc/BRIEF.md
# Dual-Path Latch/Register Bus Transceiver

This block joins two parallel buses, side A and side B, through two independent storage paths: one carries A data towards B, the other carries B data towards A. Each path can work in one of three ways. It can be transparent, so that its output follows its source bus. It can hold the value it last stored. It can be clocked, taking a new word on a rising edge of its own path strobe, and only while that path's strobe enable is active. Each path also has an active-low drive control that decides whether the path puts its word onto the far bus.

Tri-state pins are modelled as a data output plus a drive-enable output for each bus. The surrounding pad logic or bus resolver combines these into the real wire. The path strobes are ordinary control levels and are sampled by the block's system clock. Only one path may drive a given bus at a time. Keeping to that rule is the job of whoever controls the two drive inputs.

Top module: `bus_xcvr`

## Requirements
- R1: A synchronous active-high reset clears both stored words to zero, so that with transparency off both data outputs read 0 after reset.
- R2: While a path's pass input is 1, its data output equals its source bus in the same cycle, with no clock edge needed.
- R3: When pass falls from 1 to 0, the path's output keeps the source value that was present at the last system clock edge while pass was still 1, even if the source then changes.
- R4: With pass at 0 and the path strobe held at a steady level, the output keeps its stored word whatever the source bus does.
- R5: With pass at 0 and the strobe enable at 0 (active low), the path stores the source word present at the first system clock edge at which the strobe is seen at 1 after having been 0. The word appears on the output after that edge.
- R6: While the strobe enable is 1, rising strobe transitions store nothing and the output keeps its word.
- R7: A falling strobe transition never stores a word.
- R8: Each bus drive-enable output is the inverse of its path's drive_n input: 0 means drive, 1 means high impedance. The B bus is driven by the A-to-B path and the A bus by the B-to-A path.
- R9: The two paths are independent: storing, holding or passing data on one path never changes the word held by the other.
- R10: A strobe that is already at 1 when reset is released stores nothing until it has gone to 0 and back to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes and updates storage |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | W | Value currently on the A bus |
| a_out | output | W | Word the B-to-A path presents for the A bus |
| a_drv_en | output | 1 | 1 while the B-to-A path drives the A bus |
| b_in | input | W | Value currently on the B bus |
| b_out | output | W | Word the A-to-B path presents for the B bus |
| b_drv_en | output | 1 | 1 while the A-to-B path drives the B bus |
| ab_drive_n | input | 1 | Active-low drive control of the A-to-B path |
| ab_pass | input | 1 | Transparency select of the A-to-B path |
| ab_strobe | input | 1 | Capture strobe of the A-to-B path |
| ab_cke_n | input | 1 | Active-low strobe enable of the A-to-B path |
| ba_drive_n | input | 1 | Active-low drive control of the B-to-A path |
| ba_pass | input | 1 | Transparency select of the B-to-A path |
| ba_strobe | input | 1 | Capture strobe of the B-to-A path |
| ba_cke_n | input | 1 | Active-low strobe enable of the B-to-A path |

## Verification
Transparent data and drive enables are combinational, so they are due in the same cycle: the bench changes them on a falling clock edge and samples one nanosecond later. A strobe raised on a falling edge is first seen at the next rising edge, and the captured word can be read after that edge. The bench therefore changes the source bus straight after that edge and checks against the word that was on the bus at the edge. Hold, gating and falling-strobe checks let at least one full rising edge pass before sampling, so a wrong store would already be visible. A monitor on every rising edge flags any cycle in which the bench and the block drive the same bus.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Control levels of one data path.
  typedef struct packed {
    logic drive_n;  // active-low output drive
    logic pass;     // 1: transparent
    logic strobe;   // capture strobe, sampled by system clock
    logic cke_n;    // active-low strobe enable
  } xcvr_ctrl_t;

  localparam int unsigned NUM_DIRS = 2;
  localparam int unsigned DIR_AB   = 0;
  localparam int unsigned DIR_BA   = 1;

endpackage

// File: rtl/xcvr_edge_detect.sv
module xcvr_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise
);
  // The history bit resets to 1 so a strobe already high after reset
  // is not taken as a fresh edge.
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b1;
    else     level_q <= level;
  end

  assign rise = level & ~level_q;
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  xcvr_ctrl_t   ctrl,
  input  logic [W-1:0] src,
  output logic [W-1:0] dst,
  output logic         drive
);
  logic         strobe_rise;
  logic         load;
  logic [W-1:0] held;

  xcvr_edge_detect u_edge (
    .clk   (clk),
    .rst   (rst),
    .level (ctrl.strobe),
    .rise  (strobe_rise)
  );

  // Follow the source while transparent; otherwise take enabled rising strobes.
  assign load = ctrl.pass | (strobe_rise & ~ctrl.cke_n);

  xcvr_store #(.W(W)) u_store (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .d    (src),
    .q    (held)
  );

  assign dst   = ctrl.pass ? src : held;
  assign drive = ~ctrl.drive_n;
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_drv_en,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_drv_en,
  input  logic         ab_drive_n,
  input  logic         ab_pass,
  input  logic         ab_strobe,
  input  logic         ab_cke_n,
  input  logic         ba_drive_n,
  input  logic         ba_pass,
  input  logic         ba_strobe,
  input  logic         ba_cke_n
);
  xcvr_ctrl_t                  ctrl [NUM_DIRS];
  logic [NUM_DIRS-1:0][W-1:0] src;
  logic [NUM_DIRS-1:0][W-1:0] dst;
  logic [NUM_DIRS-1:0]        drv;

  always_comb begin
    ctrl[DIR_AB] = '{drive_n: ab_drive_n, pass: ab_pass, strobe: ab_strobe, cke_n: ab_cke_n};
    ctrl[DIR_BA] = '{drive_n: ba_drive_n, pass: ba_pass, strobe: ba_strobe, cke_n: ba_cke_n};
  end

  assign src[DIR_AB] = a_in;
  assign src[DIR_BA] = b_in;

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
    xcvr_path #(.W(W)) u_path (
      .clk   (clk),
      .rst   (rst),
      .ctrl  (ctrl[d]),
      .src   (src[d]),
      .dst   (dst[d]),
      .drive (drv[d])
    );
  end

  assign b_out    = dst[DIR_AB];
  assign b_drv_en = drv[DIR_AB];
  assign a_out    = dst[DIR_BA];
  assign a_drv_en = drv[DIR_BA];
endmodule

// File: rtl/bus_xcvr_checker.sv
module bus_xcvr_checker #(
  parameter int unsigned W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic         ab_pass,
  input logic         ab_strobe,
  input logic         ab_cke_n,
  input logic         ba_pass,
  input logic         ba_strobe,
  input logic         ba_cke_n
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> ((ab_pass || b_out == '0) && (ba_pass || a_out == '0)));

  p_pass_ab_r2: assert property (@(posedge clk) disable iff (rst)
    ab_pass |-> b_out == a_in);
  p_pass_ba_r2: assert property (@(posedge clk) disable iff (rst)
    ba_pass |-> a_out == b_in);

  // R4: no pass and no strobe rise means no change next cycle
  p_hold_ab_r4: assert property (@(posedge clk) disable iff (rst)
    (!ab_pass && !(ab_strobe && !$past(ab_strobe)))
      |=> (ab_pass || b_out == $past(b_out)));
  p_hold_ba_r4: assert property (@(posedge clk) disable iff (rst)
    (!ba_pass && !(ba_strobe && !$past(ba_strobe)))
      |=> (ba_pass || a_out == $past(a_out)));

  p_capture_ab_r5: assert property (@(posedge clk) disable iff (rst)
    (!ab_pass && !ab_cke_n && ab_strobe && !$past(ab_strobe) && !$past(rst))
      |=> (ab_pass || b_out == $past(a_in)));
  p_capture_ba_r5: assert property (@(posedge clk) disable iff (rst)
    (!ba_pass && !ba_cke_n && ba_strobe && !$past(ba_strobe) && !$past(rst))
      |=> (ba_pass || a_out == $past(b_in)));

  p_gate_ab_r6: assert property (@(posedge clk) disable iff (rst)
    (!ab_pass && ab_cke_n) |=> (ab_pass || b_out == $past(b_out)));
  p_gate_ba_r6: assert property (@(posedge clk) disable iff (rst)
    (!ba_pass && ba_cke_n) |=> (ba_pass || a_out == $past(a_out)));
endmodule

bind bus_xcvr bus_xcvr_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .a_in      (a_in),
  .a_out     (a_out),
  .b_in      (b_in),
  .b_out     (b_out),
  .ab_pass   (ab_pass),
  .ab_strobe (ab_strobe),
  .ab_cke_n  (ab_cke_n),
  .ba_pass   (ba_pass),
  .ba_strobe (ba_strobe),
  .ba_cke_n  (ba_cke_n)
);

// File: tb/bus_xcvr_tb_top.sv
module bus_xcvr_tb_top;
  localparam int unsigned W = 18;
  localparam logic [W-1:0] MASK = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic         pass_c  [2];
  logic         strb_c  [2];
  logic         cken_c  [2];
  logic         drvn_c  [2];
  logic         tb_on   [2];
  logic [W-1:0] src_v   [2];
  logic [W-1:0] exp_st  [2];

  logic [W-1:0] a_in, a_out, b_in, b_out;
  logic         a_drv_en, b_drv_en;

  int checks = 0;
  int failures = 0;

  // Bus resolution: the block's driver wins only when enabled.
  assign a_in = a_drv_en ? a_out : src_v[0];
  assign b_in = b_drv_en ? b_out : src_v[1];

  bus_xcvr #(.W(W)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .a_in       (a_in),
    .a_out      (a_out),
    .a_drv_en   (a_drv_en),
    .b_in       (b_in),
    .b_out      (b_out),
    .b_drv_en   (b_drv_en),
    .ab_drive_n (drvn_c[0]),
    .ab_pass    (pass_c[0]),
    .ab_strobe  (strb_c[0]),
    .ab_cke_n   (cken_c[0]),
    .ba_drive_n (drvn_c[1]),
    .ba_pass    (pass_c[1]),
    .ba_strobe  (strb_c[1]),
    .ba_cke_n   (cken_c[1])
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [W-1:0] out_of(input int d);
    return (d == 0) ? b_out : a_out;
  endfunction

  function automatic logic [W-1:0] pat(input int i, input int d);
    logic [31:0] t;
    t = (i * 32'h0002F5A3) + (d * 32'h00001357) + 32'd5;
    return t[W-1:0] ^ (W'(1) << (i % W));
  endfunction

  task automatic setup_dir(input int d);
    drvn_c[1-d] = 1'b1;
    tb_on[1-d]  = 1'b0;
    drvn_c[d]   = 1'b0;
    tb_on[d]    = 1'b1;
    #1;
    chk("R8 drive on", (d == 0) ? W'(b_drv_en) : W'(a_drv_en), W'(1));
    chk("R8 drive off", (d == 0) ? W'(a_drv_en) : W'(b_drv_en), W'(0));
  endtask

  // Contention monitor on both buses
  always @(posedge clk) begin
    if (!rst && ((tb_on[0] && a_drv_en) || (tb_on[1] && b_drv_en))) begin
      failures++;
      $display("FAIL R8 bus contention actual=1 expected=0");
    end
  end

  task automatic run_dir(input int d);
    logic [W-1:0] v;
    setup_dir(d);
    strb_c[d] = 1'b0;
    cken_c[d] = 1'b1;
    // R2 transparent sweep
    pass_c[d] = 1'b1;
    for (int i = 0; i < W; i++) begin
      src_v[d] = W'(1) << i;
      #1 chk("R2 walking one", out_of(d), W'(1) << i);
      src_v[d] = pat(i, d);
      #1 chk("R2 pattern", out_of(d), pat(i, d));
    end
    // R3 latch on pass falling
    v = pat(3, d) ^ 18'h2AAAA;
    src_v[d] = v;
    step();
    pass_c[d] = 1'b0;
    src_v[d]  = ~v;
    #1 chk("R3 held after pass fall", out_of(d), v);
    exp_st[d] = v;
    // R4 hold with strobe steady at 0 then at 1
    for (int k = 0; k < 4; k++) begin
      if (k == 2) begin
        strb_c[d] = 1'b1;  // strobe enable is off, so no capture
        step();
      end
      src_v[d] = pat(k + 40, d);
      step();
      chk("R4 hold", out_of(d), exp_st[d]);
    end
    strb_c[d] = 1'b0;
    step();
    // R5 capture sweep, R7 falling strobe
    cken_c[d] = 1'b0;
    for (int i = 0; i < W; i++) begin
      v = pat(i + 7, d);
      src_v[d] = v;
      strb_c[d] = 1'b1;
      step();
      src_v[d] = ~v;
      #1 chk("R5 capture", out_of(d), v);
      exp_st[d] = v;
      strb_c[d] = 1'b0;
      step();
      chk("R7 falling strobe", out_of(d), v);
    end
    // R6 gated strobe
    cken_c[d] = 1'b1;
    for (int k = 0; k < 3; k++) begin
      src_v[d] = pat(k + 90, d);
      strb_c[d] = 1'b1;
      step();
      strb_c[d] = 1'b0;
      step();
      chk("R6 gated", out_of(d), exp_st[d]);
    end
  endtask

  initial begin
    for (int d = 0; d < 2; d++) begin
      pass_c[d] = 1'b0; strb_c[d] = 1'b1; cken_c[d] = 1'b1;
      drvn_c[d] = 1'b1; tb_on[d] = 1'b0; src_v[d] = '0; exp_st[d] = '0;
    end
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    #1;
    chk("R1 reset b_out", b_out, '0);
    chk("R1 reset a_out", a_out, '0);
    chk("R8 idle a_drv_en", W'(a_drv_en), W'(0));
    chk("R8 idle b_drv_en", W'(b_drv_en), W'(0));
    // R10 strobe high across reset release
    setup_dir(0);
    cken_c[0] = 1'b0;
    src_v[0]  = 18'h15A5A;
    step();
    step();
    chk("R10 no capture after reset", b_out, '0);
    strb_c[0] = 1'b0;
    step();
    strb_c[0] = 1'b1;
    step();
    chk("R5 first capture after reset", b_out, 18'h15A5A);
    strb_c[0] = 1'b0;
    step();
    run_dir(0);
    chk("R9 B-to-A untouched", a_out, '0);
    run_dir(1);
    chk("R9 A-to-B untouched", b_out, exp_st[0]);
    drvn_c[1] = 1'b1;
    tb_on[1]  = 1'b0;
    #1 chk("R8 release", W'(a_drv_en), W'(0));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule